// File: doc/BRIEF.md
# Smoothly Ramping Digital Audio Attenuator

This block multiplies a stream of signed 24-bit audio samples by a gain drawn from an 11-bit attenuation code. The applied gain never jumps to a new code. A working gain register walks one linear step per accepted sample toward the latest target, so level changes are heard as short fades rather than clicks. A new target may arrive at any time, including partway through a fade, and the walk simply continues from where it stands.

The gain is the working code divided by 1024. Code 0 silences the stream, and every code from 400h upward means unity. A boost flag changes the divisor to 256, which gives four times the gain. In that case the rounded product is clipped to the signed 24-bit range. Samples come in with a valid strobe and leave one clock later with their own strobe.

Top module: `ramp_attenuator`

## Requirements
- R1: In reset, `out_valid` and `out_sample` are 0, the working gain is set to unity (code 400h) and the boost flag is clear, so the first sample after reset leaves unchanged.
- R2: Once settled at code c with boost low, each output equals the input times c/1024, rounded half up (floor of (x*c + 512)/1024).
- R3: A settled code of 000h gives an output of 0 for any input.
- R4: Target codes from 401h to 7FFh act as 400h (unity gain).
- R5: With `boost` high, the output is floor((x*c + 128)/256), clipped to the range -8388608 to 8388607.
- R6: The working gain changes by exactly one code step on each cycle with `in_valid` high, toward the target, and does not change on cycles with `in_valid` low. A sample uses the gain held before its own step.
- R7: If the target changes while a fade is under way, the next sample uses the gain already reached, and the walk goes on toward the newest target.
- R8: A fade from unity to code 0 takes 1024 samples. Sample k after the change uses gain code 1024-k, and sample 1024 and every later sample output 0.
- R9: `out_valid` is `in_valid` delayed by one clock. `out_sample` changes only on the clock after a valid input and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 24 | Signed input sample |
| target_code | input | 11 | Attenuation target code, registered each clock |
| boost | input | 1 | Selects the x4 (+12 dB) gain scale |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 24 | Signed scaled output sample |

## Verification
A wrong working-gain value shows at the port on the very next valid sample, because a known input turns the gain straight into the output value. With an input of 1024 at boost low, the output equals the gain code itself. A ramp that skips or repeats a step, or that moves on idle cycles, therefore shows up as a wrong value within one sample of the fault. A fault in the clamp, the rounding or the clipping shows up on the first settled sample whose value lands on the affected boundary.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int DEF_DATA_W  = 24;
  localparam int DEF_CODE_W  = 11;
  localparam int DEF_BOOST_S = 2;
endpackage

// File: rtl/atten_gain_ramp.sv
module atten_gain_ramp #(
  parameter int CODE_W = atten_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] target_code,
  input  logic              boost_in,
  output logic [CODE_W-1:0] gain,
  output logic              boost_q
);
  localparam logic [CODE_W-1:0] UNITY = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] tgt_q;
  logic [CODE_W-1:0] tgt_c;

  assign tgt_c = (target_code >= UNITY) ? UNITY : target_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q   <= UNITY;
      boost_q <= 1'b0;
      gain    <= UNITY;
    end else begin
      tgt_q   <= tgt_c;
      boost_q <= boost_in;
      if (in_valid) begin
        if (gain < tgt_q)      gain <= gain + CODE_W'(1);
        else if (gain > tgt_q) gain <= gain - CODE_W'(1);
      end
    end
  end

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gain != tgt_q) |=> (gain == $past(gain) + CODE_W'(1) || gain == $past(gain) - CODE_W'(1))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(gain)); // R6
  AST_SETTLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gain == tgt_q) |=> $stable(gain)); // R7
  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    gain <= UNITY); // R4
endmodule

// File: rtl/atten_scaler.sv
module atten_scaler #(
  parameter int DATA_W  = atten_pkg::DEF_DATA_W,
  parameter int CODE_W  = atten_pkg::DEF_CODE_W,
  parameter int BOOST_S = atten_pkg::DEF_BOOST_S
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic        [CODE_W-1:0] gain,
  input  logic                     boost,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);
  localparam int PW   = DATA_W + CODE_W + 1;
  localparam int SH_N = CODE_W - 1;
  localparam int SH_B = SH_N - BOOST_S;
  localparam logic signed [PW-1:0] RND_N  = PW'(64'sd1 <<< (SH_N - 1));
  localparam logic signed [PW-1:0] RND_B  = PW'(64'sd1 <<< (SH_B - 1));
  localparam logic signed [PW-1:0] SAT_HI = PW'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] SAT_LO = PW'(-(64'sd1 <<< (DATA_W - 1)));

  logic signed [PW-1:0] s_ext, g_ext, prod, biased, scaled;
  logic signed [DATA_W-1:0] clipped;

  always_comb begin
    s_ext  = PW'(in_sample);
    g_ext  = PW'({1'b0, gain});
    prod   = s_ext * g_ext;
    biased = prod + (boost ? RND_B : RND_N);
    scaled = boost ? (biased >>> SH_B) : (biased >>> SH_N);
    if (scaled > SAT_HI)      clipped = SAT_HI[DATA_W-1:0];
    else if (scaled < SAT_LO) clipped = SAT_LO[DATA_W-1:0];
    else                      clipped = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sample <= clipped;
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    ##1 (out_valid == $past(in_valid))); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_sample)); // R9
  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gain == '0) |=> out_sample == '0); // R3
endmodule

// File: rtl/ramp_attenuator.sv
module ramp_attenuator #(
  parameter int DATA_W  = atten_pkg::DEF_DATA_W,
  parameter int CODE_W  = atten_pkg::DEF_CODE_W,
  parameter int BOOST_S = atten_pkg::DEF_BOOST_S
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic        [CODE_W-1:0] target_code,
  input  logic                     boost,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);
  logic [CODE_W-1:0] gain;
  logic              boost_q;

  atten_gain_ramp #(.CODE_W(CODE_W)) u_ramp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .target_code(target_code),
    .boost_in(boost), .gain(gain), .boost_q(boost_q)
  );

  atten_scaler #(.DATA_W(DATA_W), .CODE_W(CODE_W), .BOOST_S(BOOST_S)) u_scale (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .gain(gain), .boost(boost_q), .out_valid(out_valid), .out_sample(out_sample)
  );

  AST_RESET_OUT: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sample == '0)); // R1
endmodule

// File: tb/sim_ramp_attenuator.sv
`timescale 1ns/1ps
module sim_ramp_attenuator;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [23:0] in_sample = '0;
  logic [10:0] target_code = 11'h400;
  logic boost = 1'b0;
  logic out_valid;
  logic signed [23:0] out_sample;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ramp_attenuator u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .target_code(target_code), .boost(boost),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  localparam int NV = 10;
  localparam int V_CODE [NV] = '{'h400, 'h200, 'h200, 'h7FF, 'h000, 'h100, 'h400, 'h400, 'h003, 'h001};
  localparam int V_BST  [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 0, 1};
  localparam int V_IN   [NV] = '{100000, 1001, -1001, -8388608, 8388607, 12345, 3000000, -3000000, 1000, -300};
  localparam int V_EXP  [NV] = '{100000, 501, -500, -8388608, 0, 12345, 8388607, -8388608, 3, -1};
  localparam string V_REQ [NV] = '{"R2", "R2", "R2", "R4", "R3", "R5", "R5", "R5", "R2", "R5"};

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // one valid sample; returns the output seen one clock later
  task automatic send(input int x, output int y);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 24'(x);
    @(negedge clk);
    in_valid = 1'b0;
    y = int'(out_sample);
    if (out_valid !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R9: out_valid got %0b expected 1", out_valid);
    end
  endtask

  task automatic set_target(input int c, input int b);
    @(negedge clk);
    target_code = 11'(c);
    boost = b[0];
    @(negedge clk);
  endtask

  task automatic settle();
    int y;
    for (int i = 0; i < 1025; i++) send(0, y);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int y;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 out_sample in reset", int'(out_sample), 0);
    rst = 1'b0;
    send(777, y);
    chk("R1 unity after reset", y, 777);

    // vector table
    for (int v = 0; v < NV; v++) begin
      set_target(V_CODE[v], V_BST[v]);
      settle();
      send(V_IN[v], y);
      chk(V_REQ[v], y, V_EXP[v]);
    end

    // R8 full fade unity -> mute, R6 one step per sample
    set_target('h400, 0);
    settle();
    set_target('h000, 0);
    for (int k = 0; k <= 1024; k++) begin
      send(1024, y);
      chk("R8 fade step", y, 1024 - k);
    end
    send(1024, y);
    chk("R8 stays muted", y, 0);

    // R6 idle cycles do not move the gain; R9 output holds
    set_target('h400, 0);
    for (int k = 0; k < 10; k++) send(1024, y);
    chk("R6 ramp up", y, 9);
    repeat (20) @(negedge clk);
    chk("R9 out_valid idle", int'(out_valid), 0);
    chk("R9 out_sample held", int'(out_sample), 9);
    send(1024, y);
    chk("R6 no step while idle", y, 10);

    // R7 retarget mid-fade
    for (int k = 11; k < 100; k++) send(1024, y);
    chk("R7 reached 99", y, 99);
    set_target(50, 0);
    for (int k = 0; k < 55; k++) begin
      send(1024, y);
      chk("R7 retarget walk", y, (100 - k > 50) ? 100 - k : 50);
    end

    // R1 reset mid-run restores unity
    @(negedge clk);
    rst = 1'b1;
    target_code = 11'h400;
    repeat (2) @(negedge clk);
    chk("R1 out_sample after reset", int'(out_sample), 0);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    rst = 1'b0;
    send(-4242, y);
    chk("R1 unity restored", y, -4242);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule